// File: doc/BRIEF.md
# Bitwise Logic and Bitfield Unit

This block is the logic-operation slice of a small processor datapath. Each cycle it takes a first operand, a second operand, the old value of the destination register, a 4-bit operation code, a flag-update request and a bitfield position (low bit and width). From these it forms a 32-bit result and a write-enable for the destination in the same cycle, with no register in that path.

Two condition flags, negative and zero, are kept in a register inside the block and change only on a clock edge. The operations are AND, OR, exclusive OR, OR with the complement of the second operand, bit clear, move-complement, bitfield clear and bitfield insert. A test operation ANDs the two operands only to set the flags and leaves the destination alone.

The surrounding pipeline writes `result` into the destination when `result_we` is high. It reads `flag_n` and `flag_z` one cycle after the instruction that set them.

Top module: `bitlogic_unit`

## Requirements
- R1: Op codes 0, 1 and 2 give `src_a & src_b`, `src_a | src_b` and `src_a ^ src_b`. Codes 0 to 7 drive `result_we` high.
- R2: Op code 3 gives `src_a | ~src_b`. Op code 4 gives `src_a & ~src_b`.
- R3: Op code 5 gives `~src_b`, which equals all-ones XOR `src_b`. The value of `src_a` has no effect on the result.
- R4: Op code 6 returns `dst_old` with bits from `fld_lsb` up to `fld_lsb+fld_width-1` forced to 0. A field reaching past bit 31 is cut off at bit 31. Bits outside the field keep their `dst_old` value.
- R5: Op code 7 returns `dst_old` with the low `fld_width` bits of `src_a` placed at bit `fld_lsb` upward, cut off at bit 31. All other bits keep their `dst_old` value. A width of 0 with op code 6 or 7 returns `dst_old` unchanged.
- R6: Op code 8 (test) drives `result_we` low and presents `src_a & src_b` on `result`. It always updates the flags.
- R7: On a flag update, at the next rising edge `flag_n` takes bit 31 of `result`. At the same edge `flag_z` becomes 1 when `result` is all zeros, so a one-bit mask in `src_b` reports whether that bit of `src_a` is 0.
- R8: The flags update only when `set_flags` is high or the op code is 8. Otherwise they hold their value.
- R9: Op codes 9 to 15 are no-ops. They give `result` = 0 and `result_we` = 0, and leave the flags unchanged even with `set_flags` high.
- R10: A synchronous active-high `rst` clears both flags at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_sel | input | 4 | Operation code (0 to 8 defined) |
| set_flags | input | 1 | Request a flag update from this result |
| src_a | input | 32 | First operand; bitfield source for insert |
| src_b | input | 32 | Second operand |
| dst_old | input | 32 | Current destination value, used by the bitfield operations |
| fld_lsb | input | 5 | Lowest bit of the bitfield |
| fld_width | input | 6 | Bitfield width, 0 to 32 (larger values cut off at bit 31) |
| result | output | 32 | Operation result, combinational |
| result_we | output | 1 | Destination write-enable, combinational |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The result path holds no state. A wrong field mask or a wrong operation therefore shows on `result` in the very cycle the operands are applied, and the bench compares it there. A fault in the flag register or its update condition shows one edge later: the flags move when they should hold, or they hold a stale value after a test. A mask boundary that is off by one shows only for fields touching bit 0, bit 31 or the truncation point, so those fields are applied directly, together with many random fields.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_ORN = 4'd3,
    OP_BIC = 4'd4,
    OP_MVN = 4'd5,
    OP_BFC = 4'd6,
    OP_BFI = 4'd7,
    OP_TST = 4'd8
  } logic_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/bitlogic_field_mask.sv
module bitlogic_field_mask #(
  parameter int DATA_W = 32,
  parameter int LSB_W  = $clog2(DATA_W),
  parameter int WID_W  = LSB_W + 1
) (
  input  logic [LSB_W-1:0]  fld_lsb,
  input  logic [WID_W-1:0]  fld_width,
  output logic [DATA_W-1:0] mask
);
  localparam int SUM_W = WID_W + 1;

  logic [SUM_W-1:0] lo_ext;
  logic [SUM_W-1:0] hi_excl;

  assign lo_ext  = SUM_W'(fld_lsb);
  assign hi_excl = lo_ext + SUM_W'(fld_width);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
    assign mask[i] = (IDX >= lo_ext) && (IDX < hi_excl);
  end
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
  import bitlogic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] mask,
  input  logic [LSB_W-1:0]  fld_lsb,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              op_known,
  output logic              op_test
);
  logic [DATA_W-1:0] placed;

  assign placed = src_a << fld_lsb;

  always_comb begin
    result    = '0;
    result_we = 1'b1;
    op_known  = 1'b1;
    op_test   = 1'b0;
    case (op_sel)
      OP_AND: result = src_a & src_b;
      OP_OR:  result = src_a | src_b;
      OP_XOR: result = src_a ^ src_b;
      OP_ORN: result = src_a | ~src_b;
      OP_BIC: result = src_a & ~src_b;
      OP_MVN: result = {DATA_W{1'b1}} ^ src_b;
      OP_BFC: result = dst_old & ~mask;
      OP_BFI: result = (dst_old & ~mask) | (placed & mask);
      OP_TST: begin
        result    = src_a & src_b;
        result_we = 1'b0;
        op_test   = 1'b1;
      end
      default: begin
        result_we = 1'b0;
        op_known  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bitlogic_flag_reg.sv
module bitlogic_flag_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              update,
  input  logic [DATA_W-1:0] value,
  output logic              flag_n,
  output logic              flag_z
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (update) begin
      flag_n <= value[DATA_W-1];
      flag_z <= (value == '0);
    end
  end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
  import bitlogic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LSB_W  = $clog2(DATA_W),
  parameter int WID_W  = LSB_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_sel,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [LSB_W-1:0]  fld_lsb,
  input  logic [WID_W-1:0]  fld_width,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              flag_n,
  output logic              flag_z
);
  logic [DATA_W-1:0] mask;
  logic              op_known;
  logic              op_test;
  logic              flag_upd;

  bitlogic_field_mask #(.DATA_W(DATA_W), .LSB_W(LSB_W), .WID_W(WID_W)) u_mask (
    .fld_lsb   (fld_lsb),
    .fld_width (fld_width),
    .mask      (mask)
  );

  bitlogic_core #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_core (
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_old   (dst_old),
    .mask      (mask),
    .fld_lsb   (fld_lsb),
    .result    (result),
    .result_we (result_we),
    .op_known  (op_known),
    .op_test   (op_test)
  );

  assign flag_upd = op_known & (set_flags | op_test);

  bitlogic_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .update (flag_upd),
    .value  (result),
    .flag_n (flag_n),
    .flag_z (flag_z)
  );
endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
  parameter int DATA_W = 32,
  parameter int LSB_W  = $clog2(DATA_W),
  parameter int WID_W  = LSB_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_sel,
  input logic              set_flags,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] dst_old,
  input logic [LSB_W-1:0]  fld_lsb,
  input logic [WID_W-1:0]  fld_width,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic              flag_n,
  input logic              flag_z
);
  logic upd_req;
  logic bf_op;
  assign upd_req = (op_sel <= 4'd8) && (set_flags || op_sel == 4'd8);
  assign bf_op   = (op_sel == 4'd6) || (op_sel == 4'd7);

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd8) |-> (!result_we && result == (src_a & src_b))); // R6

  AST_BFC_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd6) |-> ((result & ~dst_old) == '0)); // R4

  AST_ZERO_WIDTH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bf_op && fld_width == '0) |-> (result == dst_old)); // R5

  AST_FLAG_Z_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> (flag_z == ($past(result) == '0))); // R7

  AST_FLAG_N_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> (flag_n == $past(result[DATA_W-1]))); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_req |=> ($stable(flag_n) && $stable(flag_z))); // R8

  AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (rst)
    (op_sel > 4'd8) |-> (!result_we && result == '0)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!flag_n && !flag_z)); // R10

  logic unused_ok;
  assign unused_ok = ^{fld_lsb, fld_width};
endmodule

bind bitlogic_unit bitlogic_unit_chk #(.DATA_W(DATA_W), .LSB_W(LSB_W), .WID_W(WID_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .op_sel    (op_sel),
  .set_flags (set_flags),
  .src_a     (src_a),
  .src_b     (src_b),
  .dst_old   (dst_old),
  .fld_lsb   (fld_lsb),
  .fld_width (fld_width),
  .result    (result),
  .result_we (result_we),
  .flag_n    (flag_n),
  .flag_z    (flag_z)
);

// File: tb/test_bitlogic_unit.sv
`timescale 1ns/1ps
module test_bitlogic_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic        set_flags = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [4:0]  fld_lsb = '0;
  logic [5:0]  fld_width = '0;
  logic [31:0] result;
  logic        result_we, flag_n, flag_z;

  int n_vec = 0;
  int n_bad = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  always #5 clk = ~clk;

  bitlogic_unit i_bitlogic_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .set_flags(set_flags),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .fld_lsb(fld_lsb), .fld_width(fld_width),
    .result(result), .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic logic [31:0] model_res(int op, logic [31:0] a, logic [31:0] b,
                                            logic [31:0] d, int lo, int w);
    logic [31:0] r;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: r = a | ~b;
      4: r = a & ~b;
      5: r = ~b;
      6, 7: begin
        r = d;
        for (int i = 0; i < 32; i++)
          if (i >= lo && i < lo + w) r[i] = (op == 7) ? a[i - lo] : 1'b0;
      end
      8: r = a & b;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(string tag, int op, bit sf, logic [31:0] a, logic [31:0] b,
                       logic [31:0] d, int lo, int w);
    logic [31:0] er;
    logic        ewe;
    @(negedge clk);
    op_sel = 4'(op); set_flags = sf; src_a = a; src_b = b; dst_old = d;
    fld_lsb = 5'(lo); fld_width = 6'(w);
    er  = model_res(op, a, b, d, lo, w);
    ewe = (op <= 7);
    #1;
    check(tag, "result", result, er);
    check(tag, "result_we", 32'(result_we), 32'(ewe));
    if (op <= 8 && (sf || op == 8)) begin
      exp_n = er[31];
      exp_z = (er == 0);
    end
    @(posedge clk); #1;
    check(tag, "flags", {30'd0, flag_n, flag_z}, {30'd0, exp_n, exp_z});
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "flags after reset", {30'd0, flag_n, flag_z}, 32'd0);
    @(negedge clk); rst = 1'b0;

    apply("R1", 0, 1, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0);
    apply("R1", 1, 1, 32'h8000_0001, 32'h0000_0100, 0, 0, 0);
    apply("R1", 2, 1, 32'hAAAA_5555, 32'hAAAA_5555, 0, 0, 0);
    apply("R2", 3, 0, 32'h0000_0000, 32'hFFFF_0000, 0, 0, 0);
    apply("R2", 4, 1, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0, 0);
    apply("R3", 5, 1, 32'h1234_5678, 32'h0F0F_0F0F, 0, 0, 0);
    apply("R3", 5, 1, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 0, 0, 0);
    apply("R4", 6, 0, 0, 0, 32'hFFFF_FFFF, 4, 8);
    apply("R4", 6, 0, 0, 0, 32'hFFFF_FFFF, 28, 8);
    apply("R4", 6, 1, 0, 0, 32'hFFFF_FFFF, 0, 32);
    apply("R5", 7, 0, 32'h0000_00AB, 0, 32'h1111_1111, 8, 8);
    apply("R5", 7, 0, 32'hFFFF_FFFF, 0, 32'h0000_0000, 30, 6);
    apply("R5", 7, 0, 32'hDEAD_BEEF, 0, 32'h1357_9BDF, 12, 0);
    apply("R5", 6, 0, 0, 0, 32'h1357_9BDF, 31, 0);
    apply("R5", 7, 0, 32'hCAFE_F00D, 0, 32'h0, 0, 32);
    apply("R6", 8, 0, 32'h0000_0040, 32'h0000_0040, 32'h5, 0, 0);
    apply("R6", 8, 0, 32'hFFFF_FFBF, 32'h0000_0040, 32'h5, 0, 0);
    apply("R7", 1, 1, 32'h8000_0000, 0, 0, 0, 0);
    apply("R8", 0, 0, 0, 0, 0, 0, 0);
    apply("R8", 2, 0, 32'h8000_0000, 0, 0, 0, 0);
    apply("R9", 9, 1, 32'h1234, 32'h1234, 32'hFF, 0, 4);
    apply("R9", 15, 1, 0, 0, 0, 0, 0);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R10", "flags after mid-run reset", {30'd0, flag_n, flag_z}, 32'd0);
    exp_n = 1'b0; exp_z = 1'b0;
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom_range(0, 15));
      apply(op == 8 ? "R6" : (op > 8 ? "R9" : (op >= 6 ? "R4" : "R1")), op,
            bit'($urandom_range(0, 1)), $urandom(),
            (k % 5 == 0) ? 32'd1 << $urandom_range(0, 31) : $urandom(),
            $urandom(), int'($urandom_range(0, 31)), int'($urandom_range(0, 40)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule